// File: doc/BRIEF.md
# Dual Parallel Port with Handshake Lines

This block is a bus-attached parallel I/O adapter with two ports, A and B. Each port is `DW` bits wide, 8 by default. Each port has three registers: a direction register, an output data latch and a control register. The direction register and the data latch share one bus address. A bit in the port's control register picks which of the two that address reaches. This lets software first set the pin directions and then switch the shared address over to data traffic.

Each port also has two handshake lines.

- **Line 1** is always an input. A chosen edge on it sets a sticky status flag, which appears as bit 7 of the control register. When the flag is set and the interrupt is enabled, the flag drives that port's interrupt request output. Reading the port's data latch clears the flag.
- **Line 2** is an output. It can be held low, held high, or pulsed low for one clock after a data access. Port B pulses after a data write, which suits an output strobe to a peripheral. Port A pulses after a data read, which acknowledges an input transfer.

A typical output transfer on port B runs in three steps. Software writes the data latch, which strobes line 2. It then polls control bit 7 until the peripheral answers with an edge on line 1. Finally it reads the data address to clear the flag.

Top module: `dual_port_handshake`

## Requirements
- R1: After synchronous reset, all direction, data and control registers are zero. Every pin is an input (`pa_oe`/`pb_oe` all 0), both interrupt requests are low, and both line-2 outputs are high.
- R2: Register select encoding is: 0 = port A direction/data, 1 = port A control, 2 = port B direction/data, 3 = port B control. With control bit 2 at 0, the shared address reads and writes the direction register. With bit 2 at 1, it reads and writes the data latch.
- R3: A direction bit of 1 drives that pin from the data latch (`*_oe` bit 1, `*_out` bit equal to the latch bit). A read of the data latch returns the latch bit for output pins and the live pin level for input pins.
- R4: Control bit 1 selects the line-1 edge: 1 = rising, 0 = falling. A matching edge sets control bit 7 at the clock edge where the new level is first sampled, and the flag reads back from the next cycle on. An edge of the other polarity leaves the flag unchanged.
- R5: A read of the data latch (bit 2 = 1) clears that port's flag. A read of the direction register does not clear it. If a new matching edge arrives in the same cycle as the clearing read, the flag stays set.
- R6: Each interrupt request output equals the port's flag ANDed with control bit 0.
- R7: A control register read returns the flag in bit 7, 0 in bit 6 and the last written value in bits 5:0. Writes to bits 7:6 have no effect.
- R8: With control bits 5:3 = 101 (pulse mode), line 2 goes low for exactly the one cycle after the clock edge that completes the triggering access. The trigger is a data-latch write for port B and a data-latch read for port A.
- R9: Control bits 5:3 = 110 hold line 2 low. Value 111 and every code other than 101 and 110 hold it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select; one access per cycle in which it is high |
| rw | input | 1 | 1 = read, 0 = write |
| rsel | input | 2 | Register select (see R2) |
| wdata | input | DW | Write data bus |
| rdata | output | DW | Read data bus (combinational) |
| irq_a | output | 1 | Port A interrupt request |
| irq_b | output | 1 | Port B interrupt request |
| pa_in | input | DW | Port A pin levels |
| pa_out | output | DW | Port A output latch |
| pa_oe | output | DW | Port A per-pin output enable |
| pb_in | input | DW | Port B pin levels |
| pb_out | output | DW | Port B output latch |
| pb_oe | output | DW | Port B per-pin output enable |
| ca1 | input | 1 | Port A line 1 (edge input) |
| ca2 | output | 1 | Port A line 2 (strobe output) |
| cb1 | input | 1 | Port B line 1 (edge input) |
| cb2 | output | 1 | Port B line 2 (strobe output) |

## Verification
Read data is combinational, so a read is due in the same cycle as its select. Register writes, flag sets and flag clears show up in the cycle after the clock edge that samples them. A line-2 pulse is low in the first cycle after its access edge and high again one cycle later. The bench drives inputs on falling clock edges and compares all outputs against a behavioural model 5 ns before each rising edge. Each directed check is therefore placed in the cycle where these delays make the result due.

// File: rtl/dph_pkg.sv
package dph_pkg;

    localparam int DATA_W    = 8;
    localparam int REG_SEL_W = 2;
    localparam int CTL_W     = 6;

    typedef enum logic [REG_SEL_W-1:0] {
        SEL_A_DD  = 2'd0,
        SEL_A_CTL = 2'd1,
        SEL_B_DD  = 2'd2,
        SEL_B_CTL = 2'd3
    } reg_sel_e;

    localparam logic [2:0] L2_PULSE = 3'b101;
    localparam logic [2:0] L2_LOW   = 3'b110;

    // writable part of a control register, bit 5 down to bit 0
    typedef struct packed {
        logic [2:0] l2_mode;
        logic       sel_data;
        logic       edge_rise;
        logic       irq_en;
    } ctl_t;

    // per-port bus strobes decoded from cs/rw/rsel
    typedef struct packed {
        logic dd_rd;
        logic dd_wr;
        logic ctl_wr;
    } port_acc_t;

    function automatic logic [REG_SEL_W-1:0] dd_addr(input int p);
        return REG_SEL_W'(2 * p);
    endfunction

    function automatic logic [REG_SEL_W-1:0] ctl_addr(input int p);
        return REG_SEL_W'(2 * p + 1);
    endfunction

    function automatic logic line2_level(input logic [2:0] mode, input logic pulse);
        case (mode)
            L2_PULSE: return ~pulse;
            L2_LOW:   return 1'b0;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dph_edge_flag.sv
module dph_edge_flag (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic rise_sel,
    input  logic clr,
    output logic flag
);
    logic prev_q;
    logic flag_q;
    logic hit;

    always_comb begin
        hit = rise_sel ? (line_in & ~prev_q) : (~line_in & prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= line_in;
            flag_q <= 1'b0;
        end else begin
            prev_q <= line_in;
            if (hit)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/dph_line2.sv
module dph_line2 (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode,
    input  logic       trig,
    output logic       level
);
    import dph_pkg::*;

    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst)
            pulse_q <= 1'b0;
        else
            pulse_q <= trig;
    end

    assign level = line2_level(mode, pulse_q);
endmodule

// File: rtl/dph_port.sv
module dph_port
    import dph_pkg::*;
#(
    parameter int DW             = DATA_W,
    parameter bit PULSE_ON_WRITE = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  port_acc_t       acc,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   pin_in,
    input  logic            line1,
    output logic [DW-1:0]   pin_out,
    output logic [DW-1:0]   pin_oe,
    output logic            line2,
    output logic            irq,
    output logic [DW-1:0]   dd_rdata,
    output logic [DW-1:0]   ctl_rdata,
    output logic [CTL_W-1:0] cfg
);
    localparam int PAD_W = DW - CTL_W - 1;

    ctl_t          ctl_q;
    logic [DW-1:0] dir_q;
    logic [DW-1:0] data_q;
    logic          flag;
    logic          data_rd;
    logic          data_wr;
    logic          trig;

    always_comb begin
        data_rd = acc.dd_rd & ctl_q.sel_data;
        data_wr = acc.dd_wr & ctl_q.sel_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            dir_q  <= '0;
            data_q <= '0;
        end else begin
            if (acc.ctl_wr)
                ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
            if (acc.dd_wr) begin
                if (ctl_q.sel_data)
                    data_q <= wdata;
                else
                    dir_q <= wdata;
            end
        end
    end

    dph_edge_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line1),
        .rise_sel (ctl_q.edge_rise),
        .clr      (data_rd),
        .flag     (flag)
    );

    generate
        if (PULSE_ON_WRITE) begin : g_trig_wr
            assign trig = data_wr;
        end else begin : g_trig_rd
            assign trig = data_rd;
        end
    endgenerate

    dph_line2 u_line2 (
        .clk   (clk),
        .rst   (rst),
        .mode  (ctl_q.l2_mode),
        .trig  (trig),
        .level (line2)
    );

    always_comb begin
        dd_rdata  = ctl_q.sel_data ? ((data_q & dir_q) | (pin_in & ~dir_q)) : dir_q;
        ctl_rdata = {flag, {PAD_W{1'b0}}, ctl_q};
    end

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
    assign irq     = flag & ctl_q.irq_en;
    assign cfg     = ctl_q;
endmodule

// File: rtl/dual_port_handshake.sv
module dual_port_handshake
    import dph_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs,
    input  logic                 rw,
    input  logic [REG_SEL_W-1:0] rsel,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic                 irq_a,
    output logic                 irq_b,
    input  logic [DW-1:0]        pa_in,
    output logic [DW-1:0]        pa_out,
    output logic [DW-1:0]        pa_oe,
    input  logic [DW-1:0]        pb_in,
    output logic [DW-1:0]        pb_out,
    output logic [DW-1:0]        pb_oe,
    input  logic                 ca1,
    output logic                 ca2,
    input  logic                 cb1,
    output logic                 cb2
);
    localparam int NP = 2;

    logic [DW-1:0]    pin_in_v  [NP];
    logic [DW-1:0]    pin_out_v [NP];
    logic [DW-1:0]    pin_oe_v  [NP];
    logic [DW-1:0]    dd_rd_v   [NP];
    logic [DW-1:0]    ctl_rd_v  [NP];
    logic [CTL_W-1:0] cfg_v     [NP];
    logic [NP-1:0]    line1_v;
    logic [NP-1:0]    line2_v;
    logic [NP-1:0]    irq_v;
    logic [CTL_W-1:0] cfg_a;
    logic [CTL_W-1:0] cfg_b;

    assign pin_in_v[0] = pa_in;
    assign pin_in_v[1] = pb_in;
    assign line1_v     = {cb1, ca1};

    generate
        for (genvar g = 0; g < NP; g++) begin : g_port
            port_acc_t acc;

            always_comb begin
                acc.dd_rd  = cs &  rw & (rsel == dd_addr(g));
                acc.dd_wr  = cs & ~rw & (rsel == dd_addr(g));
                acc.ctl_wr = cs & ~rw & (rsel == ctl_addr(g));
            end

            dph_port #(
                .DW             (DW),
                .PULSE_ON_WRITE (g == 1)
            ) u_port (
                .clk       (clk),
                .rst       (rst),
                .acc       (acc),
                .wdata     (wdata),
                .pin_in    (pin_in_v[g]),
                .line1     (line1_v[g]),
                .pin_out   (pin_out_v[g]),
                .pin_oe    (pin_oe_v[g]),
                .line2     (line2_v[g]),
                .irq       (irq_v[g]),
                .dd_rdata  (dd_rd_v[g]),
                .ctl_rdata (ctl_rd_v[g]),
                .cfg       (cfg_v[g])
            );
        end
    endgenerate

    always_comb begin
        case (reg_sel_e'(rsel))
            SEL_A_DD:  rdata = dd_rd_v[0];
            SEL_A_CTL: rdata = ctl_rd_v[0];
            SEL_B_DD:  rdata = dd_rd_v[1];
            default:   rdata = ctl_rd_v[1];
        endcase
    end

    assign pa_out = pin_out_v[0];
    assign pa_oe  = pin_oe_v[0];
    assign pb_out = pin_out_v[1];
    assign pb_oe  = pin_oe_v[1];
    assign ca2    = line2_v[0];
    assign cb2    = line2_v[1];
    assign irq_a  = irq_v[0];
    assign irq_b  = irq_v[1];
    assign cfg_a  = cfg_v[0];
    assign cfg_b  = cfg_v[1];
endmodule

// File: rtl/dph_checker.sv
module dph_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cs,
    input logic          rw,
    input logic [1:0]    rsel,
    input logic [DW-1:0] rdata,
    input logic          irq_a,
    input logic          irq_b,
    input logic          ca2,
    input logic          cb2,
    input logic [DW-1:0] pa_oe,
    input logic [5:0]    cfg_a,
    input logic [5:0]    cfg_b
);
    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_a && !irq_b && pa_oe == '0 && ca2 && cb2));

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cs && !rw && rsel == 2'd0 && !cfg_a[2]) |-> $stable(pa_oe));

    // R5
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_a) |-> ($past(cs && rw && rsel == 2'd0 && cfg_a[2]) ||
                          $past(cs && !rw && rsel == 2'd1)));

    // R6
    irq_a_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> cfg_a[0]);

    // R6
    irq_b_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> cfg_b[0]);

    // R7
    ctl_bit6_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && rw && (rsel == 2'd1 || rsel == 2'd3)) |-> rdata[DW-2] == 1'b0);

    // R8
    strobe_b_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && !rw && rsel == 2'd2 && cfg_b[2] && cfg_b[5:3] == 3'b101) |=> !cb2);

    // R8
    strobe_a_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && rw && rsel == 2'd0 && cfg_a[2] && cfg_a[5:3] == 3'b101) |=> !ca2);
endmodule

bind dual_port_handshake dph_checker #(.DW(DW)) u_dph_chk (
    .clk   (clk),
    .rst   (rst),
    .cs    (cs),
    .rw    (rw),
    .rsel  (rsel),
    .rdata (rdata),
    .irq_a (irq_a),
    .irq_b (irq_b),
    .ca2   (ca2),
    .cb2   (cb2),
    .pa_oe (pa_oe),
    .cfg_a (cfg_a),
    .cfg_b (cfg_b)
);

// File: tb/dual_port_handshake_tb_top.sv
module dual_port_handshake_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0;
    logic       rw = 1'b1;
    logic [1:0] rsel = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_a, irq_b;
    logic [7:0] pa_in = 8'h30;
    logic [7:0] pb_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
    logic       ca1 = 1'b1;
    logic       cb1 = 1'b0;
    logic       ca2, cb2;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] m_dir   [2];
    logic [7:0] m_data  [2];
    logic [5:0] m_ctl   [2];
    bit         m_flag  [2];
    bit         m_prev  [2];
    bit         m_pulse [2];

    always #10 clk = ~clk;

    dual_port_handshake dut_i (
        .clk(clk), .rst(rst), .cs(cs), .rw(rw), .rsel(rsel),
        .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .ca1(ca1), .ca2(ca2), .cb1(cb1), .cb2(cb2)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit line_of(input int p);
        return (p == 1) ? cb1 : ca1;
    endfunction

    always @(posedge clk) begin
        started = 1;
        for (int p = 0; p < 2; p++) begin
            if (rst) begin
                m_dir[p] = 0; m_data[p] = 0; m_ctl[p] = 0;
                m_flag[p] = 0; m_pulse[p] = 0; m_prev[p] = line_of(p);
            end else begin
                bit ln, hit, ddh, ctlh, rdd, wrd;
                ln   = line_of(p);
                hit  = m_ctl[p][1] ? (ln && !m_prev[p]) : (!ln && m_prev[p]);
                ddh  = cs && (int'(rsel) == 2 * p);
                ctlh = cs && (int'(rsel) == 2 * p + 1);
                rdd  = ddh && rw && m_ctl[p][2];
                wrd  = ddh && !rw && m_ctl[p][2];
                if (ddh && !rw) begin
                    if (m_ctl[p][2]) m_data[p] = wdata;
                    else             m_dir[p]  = wdata;
                end
                if (ctlh && !rw) m_ctl[p] = wdata[5:0];
                if (hit)      m_flag[p] = 1;
                else if (rdd) m_flag[p] = 0;
                m_pulse[p] = (p == 1) ? wrd : rdd;
                m_prev[p]  = ln;
            end
        end
    end

    function automatic logic [7:0] exp_rdata();
        int p;
        p = int'(rsel) / 2;
        if (rsel[0]) return {m_flag[p], 1'b0, m_ctl[p]};
        if (m_ctl[p][2]) return (m_data[p] & m_dir[p]) | ((p ? pb_in : pa_in) & ~m_dir[p]);
        return m_dir[p];
    endfunction

    function automatic logic exp_line2(input int p);
        case (m_ctl[p][5:3])
            3'b101:  return !m_pulse[p];
            3'b110:  return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // per-cycle comparison against the model, 5 ns before the rising edge
    always @(negedge clk) begin
        #5;
        if (started && !rst && !done) begin
            check(rdata, exp_rdata(), "R2 rdata");
            check(pa_oe, m_dir[0], "R3 pa_oe");
            check(pa_out, m_data[0], "R3 pa_out");
            check(pb_oe, m_dir[1], "R3 pb_oe");
            check(pb_out, m_data[1], "R3 pb_out");
            check({7'd0, irq_a}, {7'd0, m_flag[0] & m_ctl[0][0]}, "R6 irq_a");
            check({7'd0, irq_b}, {7'd0, m_flag[1] & m_ctl[1][0]}, "R6 irq_b");
            check({7'd0, ca2}, {7'd0, exp_line2(0)}, "R8 ca2");
            check({7'd0, cb2}, {7'd0, exp_line2(1)}, "R8 cb2");
        end
    end

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cs = 1; rw = 0; rsel = sel; wdata = val;
        @(negedge clk);
        cs = 0; rw = 1;
    endtask

    task automatic bus_read(input logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        cs = 1; rw = 1; rsel = sel;
        #5 val = rdata;
        @(negedge clk);
        cs = 0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #5;
        // R1 reset state at the ports
        check(pa_oe, 8'h00, "R1 pa_oe");
        check({6'd0, ca2, cb2}, 8'h03, "R1 line2");
        check({6'd0, irq_a, irq_b}, 8'h00, "R1 irq");
        bus_read(2'd1, v); check(v, 8'h00, "R1 ctl A");

        // port A setup: direction 0F, data select, falling edge, irq on, pulse mode
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h0F);
        bus_write(2'd1, 8'h2D);
        bus_write(2'd0, 8'hA5);
        #5;
        check(pa_oe, 8'h0F, "R3 direction");
        check(pa_out, 8'hA5, "R3 latch");
        bus_read(2'd0, v); check(v, 8'h35, "R3 mixed read");

        // falling edge on line 1 of A
        ca1 = 0;
        bus_read(2'd1, v); check(v, 8'hAD, "R4 flag set falling");
        #1 check({7'd0, irq_a}, 8'h01, "R6 irq_a asserted");

        // direction view: read must not clear the flag
        bus_write(2'd1, 8'h29);
        bus_read(2'd0, v); check(v, 8'h0F, "R2 direction view");
        bus_read(2'd1, v); check(v, 8'hA9, "R5 dir read keeps flag");
        bus_write(2'd1, 8'h2D);
        bus_read(2'd0, v); check(v, 8'h35, "R2 data view");
        #5 check({7'd0, ca2}, 8'h00, "R8 A strobe low");
        bus_read(2'd1, v); check(v, 8'h2D, "R5 data read clears flag");
        check({7'd0, ca2}, 8'h01, "R8 A strobe back high");

        // opposite edge leaves the flag clear
        ca1 = 1;
        bus_read(2'd1, v); check(v, 8'h2D, "R4 rising ignored");

        // line-2 static modes on A
        bus_write(2'd1, 8'h35); #5 check({7'd0, ca2}, 8'h00, "R9 mode 110 low");
        bus_write(2'd1, 8'h3D); #5 check({7'd0, ca2}, 8'h01, "R9 mode 111 high");
        bus_write(2'd1, 8'h05); #5 check({7'd0, ca2}, 8'h01, "R9 mode 000 high");

        // port B output handshake: all outputs, rising edge, irq off
        bus_write(2'd3, 8'h00);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd3, 8'h2E);
        bus_write(2'd2, 8'h5A);
        #5 check({7'd0, cb2}, 8'h00, "R8 B strobe low");
        @(negedge clk); #5 check({7'd0, cb2}, 8'h01, "R8 B strobe one cycle");
        check(pb_out, 8'h5A, "R3 port B latch");
        @(negedge clk); cb1 = 1;
        v = 0;
        for (int i = 0; i < 20 && !v[7]; i++) bus_read(2'd3, v);
        check(v, 8'hAE, "R4 poll sees acknowledge");
        check({7'd0, irq_b}, 8'h00, "R6 irq_b masked");
        bus_read(2'd2, v); check(v, 8'h5A, "R3 B read all outputs");
        bus_read(2'd3, v); check(v, 8'h2E, "R5 B flag cleared");

        // clearing read and new edge in the same cycle
        cb1 = 0;
        @(negedge clk);
        cs = 1; rw = 1; rsel = 2'd2; cb1 = 1;
        @(negedge clk);
        cs = 0;
        bus_read(2'd3, v); check(v, 8'hAE, "R5 set wins over clear");

        // bits 7:6 of a control write are ignored
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, v); check(v & 8'h7F, 8'h3F, "R7 upper bits ignored");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule